// File: doc/BRIEF.md
# Compare-Match PWM Timer Channel

One 16-bit timer channel with a word-aligned register port. A programmable divider turns the system clock into count ticks. The counter advances on each tick, is compared against two compare values, and produces a pulse-width-modulated output. The output is low from the start of each period until the counter reaches compare A. It is then high until the counter reaches compare B. When clearing on B is enabled, a B match restarts the period from zero.

The channel runs only while its own bit in a start vector is set. Several channels share that start vector, and the channel takes its bit from it by a parameter. Two sticky flags record compare matches. Each flag drives an interrupt request through its own enable bit.

Software programs the divider, clear mode, output mode and compare values while the channel is stopped. It then sets the run bit. The duty cycle follows from where compare A sits between zero and compare B.

Top module: `pwm_timer_chan`

## Requirements
- R1: Registers are 16 bits wide, at byte offsets control 0x00, mode 0x04, output control 0x08, interrupt enable 0x0C, status 0x10, counter 0x14, compare A 0x18, B 0x1C, C 0x20, D 0x24. Control, mode, output control, interrupt enable and compare registers read back what was written. An access whose address has either of the two low bits set is ignored and reads 0, and so does an offset with no register. Reset clears every register.
- R2: Control bits [1:0] divide the count clock by 1, 4, 16 or 64 for codes 0 to 3. While running, the counter advances once per divided period.
- R3: With control bit 6 set, a tick that finds the counter equal to compare B loads 0. With bit 6 clear, the counter counts past B and wraps from 0xFFFF to 0.
- R4: PWM output is enabled when mode bits [3:0] equal 2 and output control bits [2:0] equal 2. In that case `pwm_out` in the cycle after a given counter value is 1 exactly when the counter is at or above compare A and compare A is below compare B.
- R5: With compare A at 0 (and B above 0), the output is high for the whole period. With compare A at or above compare B, the output stays low.
- R6: The channel runs only while bit RUN_BIT of `start_vec` is 1. The other bits have no effect. While stopped, the counter holds, the divider restarts, and `pwm_out` is 0 from the next cycle.
- R7: A write to the counter loads it. The write wins over a tick in the same cycle.
- R8: Status bit 0 latches a tick with the counter equal to compare A, and bit 1 latches one with the counter equal to compare B. A write clears each status bit written as 0 and keeps each one written as 1. A match in the same cycle as a clearing write leaves the bit set.
- R9: `irq` is 1 while some status bit in [1:0] is 1 and the interrupt-enable bit at the same position is 1.
- R10: With the PWM enable of R4 not met, `pwm_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, same cycle |
| start_vec | input | START_W | Shared start vector |
| pwm_out | output | 1 | PWM output |
| irq | output | 1 | Interrupt request |

## Verification
Two things can land on the status register in the same cycle: a compare match setting a flag, and a software write clearing that flag. The bench provokes this directly. It loads the counter with compare A, then writes zero to the status register in the next cycle while the divider is at code 0, so a tick is due. A bus read afterwards must show the flag still set. The same kind of overlap is provoked between a counter write and a tick. Throughout the random phase, a model in the bench judges each cycle: the new load value must be read back, not the incremented count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DW      = 16;
  localparam int unsigned ADDR_W  = 6;
  localparam int unsigned IDX_W   = 4;
  localparam int unsigned NUM_CMP = 4;
  localparam int unsigned CODE_W  = 2;

  typedef enum logic [IDX_W-1:0] {
    RI_CTRL = 4'd0,
    RI_MODE = 4'd1,
    RI_IOC  = 4'd2,
    RI_IEN  = 4'd3,
    RI_STAT = 4'd4,
    RI_CNT  = 4'd5,
    RI_CMPA = 4'd6,
    RI_CMPB = 4'd7,
    RI_CMPC = 4'd8,
    RI_CMPD = 4'd9
  } reg_idx_e;

  localparam int unsigned   CTRL_CLRB_BIT = 6;
  localparam logic [3:0]    MODE_PWM      = 4'd2;
  localparam logic [2:0]    IOC_LOHI      = 3'd2;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int unsigned MAX_SHIFT = 2 * ((1 << CODE_W) - 1);
  localparam int unsigned PRE_W     = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;
  logic [PRE_W:0]   one_sh;

  always_comb begin
    one_sh = (PRE_W+1)'(1) << {code, 1'b0};
    lim    = PRE_W'(one_sh - (PRE_W+1)'(1));
    tick   = run && (pre_q >= lim);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              pre_q <= '0;
    else if (!run || tick)   pre_q <= '0;
    else                     pre_q <= pre_q + 1'b1;
  end

  // R2
  pre_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && !tick |=> pre_q == $past(pre_q) + 1'b1);

  // R6
  pre_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pre_q == '0);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned W    = 16,
  parameter int unsigned NCMP = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          idx,
  input  logic [W-1:0]              wdata,
  output logic [W-1:0]              ctrl,
  output logic [W-1:0]              mode,
  output logic [W-1:0]              ioc,
  output logic [W-1:0]              ien,
  output logic [NCMP-1:0][W-1:0]    cmp
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      mode <= '0;
      ioc  <= '0;
      ien  <= '0;
    end else if (wr_en) begin
      if (idx == RI_CTRL) ctrl <= wdata;
      if (idx == RI_MODE) mode <= wdata;
      if (idx == RI_IOC)  ioc  <= wdata;
      if (idx == RI_IEN)  ien  <= wdata;
    end
  end

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(int'(RI_CMPA) + g);
    always_ff @(posedge clk) begin
      if (!rst_n)                         cmp[g] <= '0;
      else if (wr_en && idx == MY_IDX)    cmp[g] <= wdata;
    end
  end

  // R1
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && idx == RI_CTRL |=> ctrl == $past(wdata));
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         clr_on_b,
  input  logic         pwm_en,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  input  logic         cnt_wr,
  input  logic         st_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic [1:0]   flags,
  output logic         pwm_out
);
  logic hit_a, hit_b;

  always_comb begin
    hit_a = tick && (cnt == cmp_a);
    hit_b = tick && (cnt == cmp_b);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (cnt_wr)   cnt <= wdata;
    else if (tick)     cnt <= (clr_on_b && cnt == cmp_b) ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       flags <= '0;
    else if (st_wr)   flags <= (flags & wdata[1:0]) | {hit_b, hit_a};
    else              flags <= flags | {hit_b, hit_a};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pwm_out <= 1'b0;
    else        pwm_out <= run && pwm_en && (cmp_a < cmp_b) && (cnt >= cmp_a);
  end

  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !cnt_wr |=> $stable(cnt));

  // R6
  stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !pwm_out);

  // R3
  clear_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && clr_on_b && cnt == cmp_b && !cnt_wr |=> cnt == '0);

  // R7
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt == $past(wdata));

  // R8
  flag_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && cnt == cmp_a |=> flags[0]);

  // R5
  a_ge_b_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_a >= cmp_b |=> !pwm_out);
endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
  import tmr_pkg::*;
#(
  parameter int unsigned START_W = 4,
  parameter int unsigned RUN_BIT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic [START_W-1:0] start_vec,
  output logic               pwm_out,
  output logic               irq
);
  localparam logic [START_W-1:0] RUN_MASK = START_W'(1) << RUN_BIT;

  logic                    hit, wr;
  logic [IDX_W-1:0]        idx;
  logic                    run, tick, pwm_en, cnt_wr, st_wr;
  logic [DW-1:0]           ctrl, mode, ioc, ien, cnt;
  logic [NUM_CMP-1:0][DW-1:0] cmp;
  logic [1:0]              flags;

  always_comb begin
    hit    = bus_sel && (bus_addr[1:0] == 2'b00);
    wr     = hit && bus_we;
    idx    = bus_addr[ADDR_W-1:2];
    run    = |(start_vec & RUN_MASK);
    pwm_en = (mode[3:0] == MODE_PWM) && (ioc[2:0] == IOC_LOHI);
    cnt_wr = wr && (idx == RI_CNT);
    st_wr  = wr && (idx == RI_STAT);
    irq    = |(flags & ien[1:0]);
  end

  tmr_regs #(.W(DW), .NCMP(NUM_CMP)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr), .idx(idx), .wdata(bus_wdata),
    .ctrl(ctrl), .mode(mode), .ioc(ioc), .ien(ien), .cmp(cmp)
  );

  tmr_prescale #(.CODE_W(CODE_W)) pre_i (
    .clk(clk), .rst_n(rst_n), .run(run), .code(ctrl[CODE_W-1:0]), .tick(tick)
  );

  tmr_core #(.W(DW)) core_i (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
    .clr_on_b(ctrl[CTRL_CLRB_BIT]), .pwm_en(pwm_en),
    .cmp_a(cmp[0]), .cmp_b(cmp[1]), .cnt_wr(cnt_wr), .st_wr(st_wr),
    .wdata(bus_wdata), .cnt(cnt), .flags(flags), .pwm_out(pwm_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      case (idx)
        RI_CTRL: bus_rdata = ctrl;
        RI_MODE: bus_rdata = mode;
        RI_IOC:  bus_rdata = ioc;
        RI_IEN:  bus_rdata = ien;
        RI_STAT: bus_rdata = {{(DW-2){1'b0}}, flags};
        RI_CNT:  bus_rdata = cnt;
        RI_CMPA: bus_rdata = cmp[0];
        RI_CMPB: bus_rdata = cmp[1];
        RI_CMPC: bus_rdata = cmp[2];
        RI_CMPD: bus_rdata = cmp[3];
        default: bus_rdata = '0;
      endcase
    end
  end

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr && idx == RI_IEN && bus_wdata[1:0] == 2'b00 |=> !irq);

  // R10
  no_pwm_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en |=> !pwm_out);
endmodule

// File: tb/pwm_timer_chan_tb.sv
module pwm_timer_chan_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int START_W = 4;
  localparam int RUN_BIT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [START_W-1:0] start_vec = '0;
  logic pwm_out, irq;

  pwm_timer_chan #(.START_W(START_W), .RUN_BIT(RUN_BIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .start_vec(start_vec), .pwm_out(pwm_out), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [START_W-1:0] sv_cur = '0;

  // model state
  logic [15:0] m_ctrl, m_mode, m_ioc, m_ien, m_cnt;
  logic [15:0] m_cmp [4];
  logic [1:0]  m_st;
  logic        m_out;
  int          m_pre;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] mread(input logic [5:0] a);
    if (a[1:0] != 2'b00) return 16'h0;
    case (a[5:2])
      4'd0: return m_ctrl;
      4'd1: return m_mode;
      4'd2: return m_ioc;
      4'd3: return m_ien;
      4'd4: return {14'h0, m_st};
      4'd5: return m_cnt;
      4'd6: return m_cmp[0];
      4'd7: return m_cmp[1];
      4'd8: return m_cmp[2];
      4'd9: return m_cmp[3];
      default: return 16'h0;
    endcase
  endfunction

  task automatic model_reset();
    m_ctrl = 0; m_mode = 0; m_ioc = 0; m_ien = 0; m_cnt = 0;
    for (int i = 0; i < 4; i++) m_cmp[i] = 0;
    m_st = 0; m_out = 0; m_pre = 0;
  endtask

  // one cycle: drive at negedge, check read, predict, cross edge, check outputs
  task automatic step(input bit sel, input bit we, input logic [5:0] addr,
                      input logic [15:0] wd, input string tag);
    int div; bit run, tick, wr_ok; logic [3:0] wi;
    int n_pre; logic [15:0] n_cnt; logic [1:0] n_st; logic n_out;
    bus_sel = sel; bus_we = we; bus_addr = addr; bus_wdata = wd; start_vec = sv_cur;
    #1;
    if (sel && !we) chk({tag, " R1 read"}, bus_rdata, mread(addr));
    div   = 1 << (2 * int'(m_ctrl[1:0]));
    run   = sv_cur[RUN_BIT];
    tick  = run && (m_pre >= div - 1);
    wr_ok = sel && we && (addr[1:0] == 2'b00);
    wi    = addr[5:2];
    n_pre = (!run || tick) ? 0 : m_pre + 1;
    n_cnt = m_cnt;
    if (wr_ok && wi == 4'd5) n_cnt = wd;
    else if (tick) n_cnt = (m_ctrl[6] && m_cnt == m_cmp[1]) ? 16'h0 : m_cnt + 16'h1;
    n_st = m_st;
    if (wr_ok && wi == 4'd4) n_st = n_st & wd[1:0];
    if (tick && m_cnt == m_cmp[0]) n_st[0] = 1'b1;
    if (tick && m_cnt == m_cmp[1]) n_st[1] = 1'b1;
    n_out = run && (m_mode[3:0] == 4'd2) && (m_ioc[2:0] == 3'd2) &&
            (m_cmp[0] < m_cmp[1]) && (m_cnt >= m_cmp[0]);
    if (wr_ok) begin
      case (wi)
        4'd0: m_ctrl = wd;
        4'd1: m_mode = wd;
        4'd2: m_ioc  = wd;
        4'd3: m_ien  = wd;
        4'd6: m_cmp[0] = wd;
        4'd7: m_cmp[1] = wd;
        4'd8: m_cmp[2] = wd;
        4'd9: m_cmp[3] = wd;
        default: ;
      endcase
    end
    @(posedge clk);
    m_pre = n_pre; m_cnt = n_cnt; m_st = n_st; m_out = n_out;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    chk({tag, " R4 pwm"}, {15'h0, pwm_out}, {15'h0, m_out});
    chk("R9 irq", {15'h0, irq}, {15'h0, |(m_st & m_ien[1:0])});
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d, input string tag);
    step(1, 1, a, d, tag);
  endtask

  task automatic rd(input logic [5:0] a, input string tag);
    step(1, 0, a, 16'h0, tag);
  endtask

  task automatic watch(input int n, input string tag);
    for (int i = 0; i < n; i++) rd((i % 3 == 2) ? 6'h10 : 6'h14, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // reset state, R1
    chk("R1 reset pwm", {15'h0, pwm_out}, 16'h0);
    chk("R9 reset irq", {15'h0, irq}, 16'h0);
    for (int a = 0; a < 12; a++) rd(6'(a * 4), "R1 reset");

    // R1 register map readback while stopped
    wr(6'h00, 16'hA5B3, "R1"); wr(6'h04, 16'h1234, "R1"); wr(6'h08, 16'h0F0F, "R1");
    wr(6'h0C, 16'hFFFC, "R1"); wr(6'h14, 16'h4321, "R1"); wr(6'h18, 16'h0101, "R1");
    wr(6'h1C, 16'h0202, "R1"); wr(6'h20, 16'hC0C0, "R1"); wr(6'h24, 16'hD0D0, "R1");
    wr(6'h10, 16'hFFFF, "R8");
    for (int a = 0; a < 12; a++) rd(6'(a * 4), "R1 map");
    wr(6'h01, 16'h0000, "R1 misaligned"); rd(6'h00, "R1 misaligned ignored");
    rd(6'h02, "R1 misaligned read");

    // R4 basic PWM: A=3 B=9 clear on B, divide 1
    wr(6'h00, 16'h0040, "R3"); wr(6'h04, 16'h0002, "R4"); wr(6'h08, 16'h0002, "R4");
    wr(6'h18, 16'd3, "R4"); wr(6'h1C, 16'd9, "R4"); wr(6'h14, 16'd0, "R7");
    wr(6'h0C, 16'h0003, "R9");
    sv_cur = 4'b0100;
    watch(40, "R4");
    // R8 flag clear with write-1-keeps
    wr(6'h10, 16'h0002, "R8"); rd(6'h10, "R8");
    // R5 corner values
    wr(6'h18, 16'd0, "R5"); watch(25, "R5 A=0");
    wr(6'h18, 16'd9, "R5"); watch(25, "R5 A=B");
    wr(6'h18, 16'd12, "R5"); watch(15, "R5 A>B");
    // R2 prescaler codes
    wr(6'h18, 16'd2, "R2"); wr(6'h1C, 16'd4, "R2");
    wr(6'h00, 16'h0041, "R2"); watch(60, "R2 div4");
    wr(6'h00, 16'h0042, "R2"); watch(200, "R2 div16");
    wr(6'h00, 16'h0043, "R2"); watch(700, "R2 div64");
    // R3 no clear: wraps past B and past 0xFFFF
    wr(6'h00, 16'h0000, "R3"); wr(6'h1C, 16'd5, "R3");
    wr(6'h14, 16'hFFFD, "R3"); watch(20, "R3 wrap");
    // R7 counter write during ticking
    wr(6'h14, 16'h0100, "R7"); rd(6'h14, "R7");
    // R8 collision: match and clear same cycle, set wins
    wr(6'h00, 16'h0040, "R8"); wr(6'h1C, 16'd6, "R8");
    wr(6'h10, 16'h0000, "R8"); wr(6'h14, 16'd2, "R8");
    wr(6'h10, 16'h0000, "R8 collide"); rd(6'h10, "R8 set wins");
    // R6 stop: other start bits have no effect
    sv_cur = 4'b1011; watch(20, "R6 stopped");
    sv_cur = 4'b0000; watch(10, "R6 stopped");
    sv_cur = 4'b0100; watch(10, "R6 running");
    // R10 mode off
    wr(6'h04, 16'h0000, "R10"); watch(20, "R10");
    wr(6'h04, 16'h0002, "R10"); wr(6'h08, 16'h0003, "R10"); watch(20, "R10 ioc");
    wr(6'h08, 16'h0002, "R10");

    // random phase
    for (int i = 0; i < 5000; i++) begin
      int unsigned r = $urandom % 100;
      logic [15:0] d = 16'($urandom);
      if (i % 37 == 0) sv_cur = ($urandom % 5 == 0) ? 4'(($urandom) & 4'b1011) : 4'($urandom | 4'b0100);
      if (r < 60) rd(6'(($urandom % 12) * 4), "R1 rand");
      else begin
        int unsigned k = $urandom % 10;
        case (k)
          0: wr(6'h00, {d[15:7], 1'b1, d[5:2], 2'(d[1:0] & 2'b01)}, "R2 rand");
          1: wr(6'h04, ($urandom % 4 == 0) ? d : 16'h0002, "R10 rand");
          2: wr(6'h08, ($urandom % 4 == 0) ? d : 16'h0002, "R10 rand");
          3: wr(6'h0C, d, "R9 rand");
          4: wr(6'h10, d, "R8 rand");
          5: wr(6'h14, ($urandom % 3 == 0) ? d : 16'($urandom % 20), "R7 rand");
          6, 7: wr(6'h18, 16'($urandom % 16), "R5 rand");
          8: wr(6'h1C, 16'($urandom % 16), "R3 rand");
          default: wr(6'(($urandom % 16) * 4 + 1), d, "R1 rand misaligned");
        endcase
      end
    end
    finish_run();
  end
endmodule